// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block is the digital control core of a synchronous buck half-bridge. It takes one PWM command and produces two gate enables, one for the high-side switch and one for the low-side switch. The dead time is not fixed. Before either enable turns on, the block waits for a comparator flag showing that the opposite switch has actually turned off. All analog sensing arrives as single-bit comparator flags that are already synchronous to the clock.

A PWM level held in the mid-level window for a programmable hold-off time forces both enables low. Normal decoding resumes as soon as the level leaves the window. A supply monitor with rising and falling thresholds gates all switching. Before the supply first comes up, the block signals a protection mode so that an external clamp path can own the low-side gate. That mode is not entered again until the block is reset. A timeout guards each wait for feedback: if a comparator flag never arrives, a sticky fault holds both gates off.

Top module: `dts_gate_seq`

## Requirements
- R1: A PWM high level (pwm_i=1 with pwm_mid_i=0) first removes lo_en_o. hi_en_o stays low for as long as lg_low_i is 0.
- R2: hi_en_o rises exactly PROP_DLY_CYC clock cycles after the cycle in which lg_low_i was first sampled high during a rising transition.
- R3: A PWM low level removes hi_en_o. lo_en_o rises one cycle after ph_low_i or hg_ph_low_i is sampled high, whichever comes first.
- R4: hi_en_o and lo_en_o are never high in the same cycle.
- R5: When pwm_mid_i is sampled high on HOLDOFF_CYC consecutive edges, both enables go low at that edge and stay low while pwm_mid_i stays high.
- R6: The shutdown ends on the first edge that samples pwm_mid_i low. Decoding of pwm_i then resumes and the normal sequence runs.
- R7: A mid-level pass shorter than HOLDOFF_CYC cycles clears the hold-off count and has no effect on the enables.
- R8: Switching is enabled on the edge after sup_rise_i is sampled high. It is disabled (both enables low) on the edge that samples sup_fall_i high, and it stays disabled until sup_rise_i is seen again.
- R9: From reset until the supply first rises, prot_mode_o is 1 and both enables are 0, whatever pwm_i does.
- R10: Once the supply has risen, prot_mode_o stays 0 through later supply drops and recoveries. Only rst_ni sets it to 1 again.
- R11: After enabling, both enables stay low until pwm_mid_i is low, so that pwm_i carries a valid level.
- R12: If a wait for a comparator flag lasts TIMEOUT_CYC cycles, fault_o becomes 1 and both enables stay 0 until rst_ni.
- R13: A PWM level change during a wait aborts it. The opposite sequence then starts from the both-off state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwm_i | input | 1 | PWM level, valid when pwm_mid_i is 0 |
| pwm_mid_i | input | 1 | PWM inside the mid-level shutdown window |
| lg_low_i | input | 1 | Low-side gate below its turn-off threshold |
| ph_low_i | input | 1 | Switch node below its threshold |
| hg_ph_low_i | input | 1 | High gate to switch node below its threshold |
| sup_rise_i | input | 1 | Supply above the rising threshold |
| sup_fall_i | input | 1 | Supply below the falling threshold |
| hi_en_o | output | 1 | High-side gate enable |
| lo_en_o | output | 1 | Low-side gate enable |
| prot_mode_o | output | 1 | Pre-reset protection owns the low-side gate |
| fault_o | output | 1 | Feedback timeout, sticky until reset |

## Verification
The assertions assume that the comparator flags are clean, clock-synchronous levels, that pwm_i carries meaning only while pwm_mid_i is low, and that sup_rise_i and sup_fall_i are never high together. The stimulus changes every input on the falling clock edge, keeps the two supply flags mutually exclusive, and raises the feedback flags only in a physically plausible order. For example, lg_low_i is held high while the high side is on.

// File: rtl/dts_pkg.sv
package dts_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_LO_OFF = 3'd1,
    ST_HI_DLY = 3'd2,
    ST_HI_ON  = 3'd3,
    ST_HI_OFF = 3'd4,
    ST_LO_ON  = 3'd5,
    ST_FAULT  = 3'd6
  } seq_state_e;
endpackage

// File: rtl/dts_supply_mon.sv
module dts_supply_mon (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sup_rise_i,
  input  logic sup_fall_i,
  output logic run_o,
  output logic prot_o
);
  logic run_q, armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      armed_q <= 1'b1;
    end else if (!run_q && sup_rise_i) begin
      run_q   <= 1'b1;
      armed_q <= 1'b0;
    end else if (run_q && sup_fall_i) begin
      run_q   <= 1'b0;
    end
  end

  assign run_o  = run_q;
  assign prot_o = armed_q;

  a_r10_no_rearm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |=> !armed_q);
  a_r8_hold_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !sup_fall_i) |=> run_q);
  a_r8_drop_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && sup_fall_i) |=> !run_q);
endmodule

// File: rtl/dts_shutdown_filt.sv
module dts_shutdown_filt #(
  parameter int HOLDOFF_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mid_i,
  output logic sd_o
);
  localparam int CW = $clog2(HOLDOFF_CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(HOLDOFF_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          sd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sd_q  <= 1'b0;
    end else if (!mid_i) begin
      cnt_q <= '0;
      sd_q  <= 1'b0;
    end else if (!sd_q) begin
      if (cnt_q == LIM) begin
        sd_q  <= 1'b1;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign sd_o = sd_q;

  a_r5_sd_needs_mid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sd_q) |-> $past(mid_i));
  a_r6_sd_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mid_i |=> !sd_q);
endmodule

// File: rtl/dts_seq_fsm.sv
module dts_seq_fsm
  import dts_pkg::*;
#(
  parameter int PROP_DLY_CYC = 4,
  parameter int TIMEOUT_CYC  = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic pwm_i,
  input  logic mid_i,
  input  logic lg_low_i,
  input  logic ph_low_i,
  input  logic hg_ph_low_i,
  output logic hi_en_o,
  output logic lo_en_o,
  output logic fault_o
);
  localparam int DW = $clog2(PROP_DLY_CYC + 1);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [DW-1:0] DLIM = DW'(PROP_DLY_CYC - 1);
  localparam logic [TW-1:0] TLIM = TW'(TIMEOUT_CYC - 1);

  seq_state_e    state_q, state_d;
  logic [DW-1:0] dcnt_q;
  logic [TW-1:0] wcnt_q;
  logic          want_hi, want_lo, waiting;

  assign want_hi = !mid_i && pwm_i;
  assign want_lo = !mid_i && !pwm_i;
  assign waiting = (state_q == ST_LO_OFF) || (state_q == ST_HI_OFF);

  always_comb begin
    state_d = state_q;
    if (state_q == ST_FAULT) begin
      state_d = ST_FAULT;
    end else if (!en_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (want_hi)      state_d = ST_LO_OFF;
          else if (want_lo) state_d = ST_HI_OFF;
        end
        ST_LO_ON:  if (want_hi) state_d = ST_LO_OFF;
        ST_LO_OFF: begin
          if (want_lo)             state_d = ST_HI_OFF;
          else if (lg_low_i)       state_d = ST_HI_DLY;
          else if (wcnt_q == TLIM) state_d = ST_FAULT;
        end
        ST_HI_DLY: begin
          if (want_lo)             state_d = ST_HI_OFF;
          else if (dcnt_q == DLIM) state_d = ST_HI_ON;
        end
        ST_HI_ON:  if (want_lo) state_d = ST_HI_OFF;
        ST_HI_OFF: begin
          if (want_hi)                     state_d = ST_LO_OFF;
          else if (ph_low_i || hg_ph_low_i) state_d = ST_LO_ON;
          else if (wcnt_q == TLIM)         state_d = ST_FAULT;
        end
        default: state_d = ST_FAULT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      dcnt_q  <= '0;
      wcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_d != state_q) begin
        dcnt_q <= '0;
        wcnt_q <= '0;
      end else begin
        if (state_q == ST_HI_DLY) dcnt_q <= dcnt_q + 1'b1;
        if (waiting)              wcnt_q <= wcnt_q + 1'b1;
      end
    end
  end

  // gate with enable so a shutdown or supply drop acts in the same cycle
  assign hi_en_o = (state_q == ST_HI_ON) && en_i;
  assign lo_en_o = (state_q == ST_LO_ON) && en_i;
  assign fault_o = (state_q == ST_FAULT);

  a_r4_never_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hi_en_o && lo_en_o));
  a_r1_hi_after_lg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HI_DLY && $past(state_q) == ST_LO_OFF) |-> $past(lg_low_i));
  a_r3_lo_after_fb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LO_ON && $past(state_q) == ST_HI_OFF)
      |-> $past(ph_low_i || hg_ph_low_i));
  a_r12_fault_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> (fault_o && !hi_en_o && !lo_en_o));
endmodule

// File: rtl/dts_gate_seq.sv
module dts_gate_seq #(
  parameter int PROP_DLY_CYC = 4,
  parameter int HOLDOFF_CYC  = 16,
  parameter int TIMEOUT_CYC  = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwm_i,
  input  logic pwm_mid_i,
  input  logic lg_low_i,
  input  logic ph_low_i,
  input  logic hg_ph_low_i,
  input  logic sup_rise_i,
  input  logic sup_fall_i,
  output logic hi_en_o,
  output logic lo_en_o,
  output logic prot_mode_o,
  output logic fault_o
);
  logic run, prot, sd, en;

  dts_supply_mon u_sup (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sup_rise_i (sup_rise_i),
    .sup_fall_i (sup_fall_i),
    .run_o      (run),
    .prot_o     (prot)
  );

  dts_shutdown_filt #(.HOLDOFF_CYC(HOLDOFF_CYC)) u_sd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mid_i  (pwm_mid_i),
    .sd_o   (sd)
  );

  assign en = run && !sd;

  dts_seq_fsm #(.PROP_DLY_CYC(PROP_DLY_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en),
    .pwm_i       (pwm_i),
    .mid_i       (pwm_mid_i),
    .lg_low_i    (lg_low_i),
    .ph_low_i    (ph_low_i),
    .hg_ph_low_i (hg_ph_low_i),
    .hi_en_o     (hi_en_o),
    .lo_en_o     (lo_en_o),
    .fault_o     (fault_o)
  );

  assign prot_mode_o = prot;

  a_r9_prot_gates_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_mode_o |-> (!hi_en_o && !lo_en_o));
  a_r5_sd_gates_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sd |-> (!hi_en_o && !lo_en_o));
endmodule

// File: tb/dts_gate_seq_tb_top.sv
module dts_gate_seq_tb_top;
  localparam int PROP = 4;
  localparam int HOLD = 16;
  localparam int TOUT = 64;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pwm = 1'b0, mid = 1'b1, lg_low = 1'b0, ph_low = 1'b0, hg_low = 1'b0;
  logic sup_rise = 1'b0, sup_fall = 1'b0;
  logic hi, lo, prot, fault;
  int n_chk = 0, n_bad = 0;
  bit both_seen = 0;

  always #2.5 clk = ~clk;

  dts_gate_seq #(.PROP_DLY_CYC(PROP), .HOLDOFF_CYC(HOLD), .TIMEOUT_CYC(TOUT)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .pwm_i(pwm), .pwm_mid_i(mid),
    .lg_low_i(lg_low), .ph_low_i(ph_low), .hg_ph_low_i(hg_low),
    .sup_rise_i(sup_rise), .sup_fall_i(sup_fall),
    .hi_en_o(hi), .lo_en_o(lo), .prot_mode_o(prot), .fault_o(fault)
  );

  always @(negedge clk) if (rst_ni && hi && lo) both_seen = 1;

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic go_hi();
    pwm = 1; mid = 0; lg_low = 1; ph_low = 0; hg_low = 0;
    step(2 + PROP);
  endtask

  task automatic t_reset();
    chk("R9", "hi at reset", hi, 0);
    chk("R9", "lo at reset", lo, 0);
    chk("R9", "prot at reset", prot, 1);
    chk("R12", "fault at reset", fault, 0);
  endtask

  task automatic t_prepor();
    pwm = 1; mid = 0; lg_low = 1; ph_low = 1;
    step(10);
    chk("R9", "hi before supply", hi, 0);
    chk("R9", "lo before supply", lo, 0);
    chk("R9", "prot before supply", prot, 1);
    pwm = 0; mid = 1; lg_low = 0; ph_low = 0;
  endtask

  task automatic t_powerup();
    sup_rise = 1; step(1); sup_rise = 0;
    chk("R8", "prot after rise", prot, 0);
    step(5);
    chk("R11", "hi while mid", hi, 0);
    chk("R11", "lo while mid", lo, 0);
    mid = 0; pwm = 0; ph_low = 1;
    step(4);
    chk("R11", "lo after valid low", lo, 1);
    ph_low = 0;
  endtask

  task automatic t_rise();
    lg_low = 0; pwm = 1;
    step(1);
    chk("R1", "lo off first", lo, 0);
    chk("R1", "hi not yet", hi, 0);
    step(10);
    chk("R1", "hi waits lg_low", hi, 0);
    lg_low = 1;
    step(PROP);
    chk("R2", "hi before delay", hi, 0);
    step(1);
    chk("R2", "hi after delay", hi, 1);
  endtask

  task automatic t_fall_hg();
    pwm = 0;
    step(1);
    chk("R3", "hi off on fall", hi, 0);
    chk("R3", "lo waits", lo, 0);
    step(5);
    chk("R3", "lo waits fb", lo, 0);
    hg_low = 1;
    step(1);
    chk("R3", "lo on hg flag", lo, 1);
    hg_low = 0;
  endtask

  task automatic t_fall_ph();
    go_hi();
    chk("R2", "hi on", hi, 1);
    pwm = 0; ph_low = 1;
    step(1);
    chk("R3", "lo one cycle later", lo, 0);
    step(1);
    chk("R3", "lo on ph flag", lo, 1);
    ph_low = 0;
  endtask

  task automatic t_short_mid();
    go_hi();
    mid = 1;
    step(HOLD - 1);
    chk("R7", "hi during short mid", hi, 1);
    mid = 0;
    step(2);
    chk("R7", "hi after short mid", hi, 1);
  endtask

  task automatic t_shutdown();
    mid = 1;
    step(HOLD - 1);
    chk("R5", "hi before holdoff", hi, 1);
    step(1);
    chk("R5", "hi at holdoff", hi, 0);
    chk("R5", "lo at holdoff", lo, 0);
    pwm = 0; ph_low = 1;
    step(10);
    chk("R5", "lo held in shutdown", lo, 0);
    ph_low = 0; pwm = 1; lg_low = 1; mid = 0;
    step(2 + PROP);
    chk("R6", "hi not yet after exit", hi, 0);
    step(1);
    chk("R6", "hi resumes", hi, 1);
  endtask

  task automatic t_abort();
    pwm = 0; ph_low = 0; hg_low = 0;
    step(3);
    chk("R13", "both off in wait", hi | lo, 0);
    pwm = 1; lg_low = 1;
    step(1 + PROP);
    chk("R13", "hi not yet after abort", hi, 0);
    step(1);
    chk("R13", "hi after abort", hi, 1);
  endtask

  task automatic t_por_drop();
    sup_fall = 1; step(1); sup_fall = 0;
    chk("R8", "hi after supply drop", hi, 0);
    chk("R10", "prot after drop", prot, 0);
    step(5);
    chk("R8", "hi stays off", hi, 0);
    chk("R10", "prot stays low", prot, 0);
    sup_rise = 1; step(1); sup_rise = 0;
    chk("R10", "prot after recovery", prot, 0);
    step(2 + PROP);
    chk("R8", "hi after recovery", hi, 1);
  endtask

  task automatic t_timeout();
    pwm = 0; ph_low = 0; hg_low = 0;
    step(TOUT - 5);
    chk("R12", "no fault yet", fault, 0);
    step(20);
    chk("R12", "fault on timeout", fault, 1);
    chk("R12", "both off in fault", hi | lo, 0);
    ph_low = 1;
    step(5);
    chk("R12", "lo held in fault", lo, 0);
    chk("R12", "fault sticky", fault, 1);
    rst_ni = 0; step(2); rst_ni = 1; step(1);
    chk("R12", "fault cleared by reset", fault, 0);
    chk("R10", "prot rearmed by reset", prot, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    step(3);
    rst_ni = 1;
    step(1);
    t_reset();
    t_prepor();
    t_powerup();
    t_rise();
    t_fall_hg();
    t_fall_ph();
    t_short_mid();
    t_shutdown();
    t_abort();
    t_por_drop();
    t_timeout();
    chk("R4", "never both on", both_seen, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule